// File: doc/BRIEF.md
# Successive Approximation Conversion Sequencer

This block is the digital control for an 8-bit successive-approximation analog-to-digital converter. A one-cycle start request, qualified by a 3-bit channel number and a clock-speed choice, begins a conversion. The block routes the chosen input through an 8-way analog multiplexer select and opens a sample-and-hold window. It then resolves the code one bit at a time, starting from the most significant bit, by presenting a trial word to an external DAC and reading back a single comparator bit. The comparator, the DAC and the sample capacitor sit outside this block.

Every conversion occupies a fixed frame of 26 conversion-clock periods. The first 6 periods are sampling. Eight decisions of 2 periods each follow, and a 4-period tail closes the frame, at whose end the code is latched. The conversion clock is either the system clock itself or the system clock divided by a parameter. Divided operation is intended for system clocks above 14 MHz. A sticky done flag tells the host that a fresh result is waiting. The host clears the flag by reading the result or by starting again.

Top module: `adc_sar_seq`

## Requirements
- R1: A start request seen while idle makes busy_o rise on the next clock edge. busy_o then stays high for exactly 26 conversion periods and falls on the edge that ends the last period.
- R2: A conversion period lasts one system cycle when fast_clk_i is 1 at the accepted start. Otherwise it lasts DIV system cycles (default 4). The choice is captured at start, and later changes of fast_clk_i have no effect on a running conversion.
- R3: sample_o is high during conversion periods 0 to 5 and low in every other period and while idle.
- R4: mux_sel_o takes the value of chan_i at the accepted start and holds it until the next accepted start.
- R5: Bits are decided most significant first. During periods 6+2i and 7+2i (i = 0..7), bit 7-i of dac_o is 1 and all lower bits are 0. Each higher bit keeps its decided value.
- R6: At the end of period 7+2i, bit 7-i is kept if cmp_i is 1 (input at or above the DAC level) and cleared otherwise. result_o is loaded with the final code on the edge where busy_o falls and keeps it until the next completion. With an ideal comparator, the result equals the input code.
- R7: done_o is set on the same edge where busy_o falls and stays set until cleared.
- R8: done_o is cleared on the edge that samples rd_result_i high, or on the edge that accepts a start. If completion and a read fall on the same edge, completion wins and done_o is set.
- R9: A start request while busy is ignored. The channel, the period count, the frame length and the result are unaffected.
- R10: After reset, busy_o, done_o and sample_o are 0, and result_o, dac_o and mux_sel_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Conversion request, sampled each edge |
| chan_i | input | 3 | Channel to convert, taken at accepted start |
| fast_clk_i | input | 1 | 1: conversion clock equals system clock; 0: divided by DIV |
| rd_result_i | input | 1 | Result read strobe, clears done |
| cmp_i | input | 1 | Comparator: 1 when input is at or above the DAC level |
| mux_sel_o | output | 3 | Analog multiplexer select |
| sample_o | output | 1 | Sample-and-hold switch closed |
| dac_o | output | 8 | Trial word driven to the DAC |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | Sticky completion flag |
| result_o | output | 8 | Last converted code |

## Verification
A period counter that slips by one shows at once as a sample window or trial bit shifted against the expected period, and as busy_o falling one period early or late. A wrong captured channel or clock choice changes mux_sel_o or the frame length within the first period. A decision stored into the wrong bit, or taken against the wrong comparator sense, shows on dac_o in the very next decision period, well before result_o differs. A done flag that mishandles set against clear is visible in the cycle after completion, a read or a new start.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    // Coarse phase of a conversion frame
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SAMPLE = 2'd1,
        PH_DECIDE = 2'd2,
        PH_TAIL   = 2'd3
    } conv_phase_e;

endpackage

// File: rtl/adc_prescaler.sv
// Conversion-clock enable: one tick per conversion period while running.
module adc_prescaler #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic restart_i,
    input  logic fast_i,
    output logic tick_o
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    typedef struct packed {
        logic [PW-1:0] cnt;
    } pre_state_t;

    pre_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        tick_o = run_i && (fast_i || (st_q.cnt == LAST));
        if (restart_i || !run_i) begin
            st_d.cnt = '0;
        end else if (fast_i || st_q.cnt == LAST) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Divided clock never gives two ticks in a row
    p_div_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !fast_i && tick_o && !restart_i) |=> !tick_o);

endmodule

// File: rtl/adc_phase_ctrl.sv
// Frame counter: sample window, bit decisions, settle tail.
module adc_phase_ctrl
    import adc_seq_pkg::*;
#(
    parameter int RES_W      = 8,
    parameter int SAMPLE_LEN = 6,
    parameter int BIT_LEN    = 2,
    parameter int TAIL_LEN   = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_ok_i,
    input  logic                     tick_i,
    output logic                     busy_o,
    output logic                     sample_o,
    output logic                     decide_o,
    output logic [$clog2(RES_W)-1:0] bit_idx_o,
    output logic                     strobe_o,
    output logic                     finish_o
);
    localparam int DEC_END = SAMPLE_LEN + RES_W * BIT_LEN;
    localparam int FRAME   = DEC_END + TAIL_LEN;
    localparam int CW      = $clog2(FRAME + 1);
    localparam int BW      = $clog2(RES_W);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } frame_state_t;

    frame_state_t st_d, st_q;
    conv_phase_e  phase;
    int           cnt_i;
    int           off_i;

    assign cnt_i = int'(st_q.cnt);
    assign off_i = cnt_i - SAMPLE_LEN;

    always_comb begin
        if (!st_q.busy) begin
            phase = PH_IDLE;
        end else if (cnt_i < SAMPLE_LEN) begin
            phase = PH_SAMPLE;
        end else if (cnt_i < DEC_END) begin
            phase = PH_DECIDE;
        end else begin
            phase = PH_TAIL;
        end
    end

    always_comb begin
        st_d      = st_q;
        busy_o    = st_q.busy;
        sample_o  = (phase == PH_SAMPLE);
        decide_o  = (phase == PH_DECIDE);
        bit_idx_o = '0;
        strobe_o  = 1'b0;
        finish_o  = st_q.busy && tick_i && (cnt_i == FRAME - 1);
        if (phase == PH_DECIDE) begin
            bit_idx_o = BW'(RES_W - 1 - off_i / BIT_LEN);
            strobe_o  = tick_i && ((off_i % BIT_LEN) == BIT_LEN - 1);
        end
        if (start_ok_i) begin
            st_d.busy = 1'b1;
            st_d.cnt  = '0;
        end else if (finish_o) begin
            st_d.busy = 1'b0;
            st_d.cnt  = '0;
        end else if (st_q.busy && tick_i) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    p_frame_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> (cnt_i < FRAME));

    p_sample_ends_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sample_o) |-> (st_q.busy && cnt_i == SAMPLE_LEN));

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.busy |-> (st_q.cnt == '0 && !strobe_o));

endmodule

// File: rtl/adc_sar_core.sv
// Trial register and result latch.
module adc_sar_core #(
    parameter int RES_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_ok_i,
    input  logic                     decide_i,
    input  logic [$clog2(RES_W)-1:0] bit_idx_i,
    input  logic                     strobe_i,
    input  logic                     finish_i,
    input  logic                     cmp_i,
    output logic [RES_W-1:0]         dac_o,
    output logic [RES_W-1:0]         result_o
);
    typedef struct packed {
        logic [RES_W-1:0] trial;
        logic [RES_W-1:0] result;
    } sar_state_t;

    sar_state_t       st_d, st_q;
    logic [RES_W-1:0] probe;
    logic [RES_W-1:0] low_mask;

    always_comb begin
        probe    = '0;
        low_mask = '0;
        for (int b = 0; b < RES_W; b++) begin
            if (decide_i && b == int'(bit_idx_i)) begin
                probe[b] = 1'b1;
            end
            if (decide_i && b < int'(bit_idx_i)) begin
                low_mask[b] = 1'b1;
            end
        end
    end

    always_comb begin
        st_d  = st_q;
        dac_o = st_q.trial | probe;
        if (start_ok_i) begin
            st_d.trial = '0;
        end else if (strobe_i) begin
            st_d.trial[bit_idx_i] = cmp_i;
        end
        if (finish_i) begin
            st_d.result = st_q.trial;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result_o = st_q.result;

    p_lower_bits_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        decide_i |-> ((st_q.trial & low_mask) == '0));

    p_result_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !finish_i |=> $stable(result_o));

endmodule

// File: rtl/adc_sar_seq.sv
// Top: start qualification, captured settings and sticky done flag.
module adc_sar_seq #(
    parameter int RES_W      = 8,
    parameter int CH_W       = 3,
    parameter int DIV        = 4,
    parameter int SAMPLE_LEN = 6,
    parameter int BIT_LEN    = 2,
    parameter int TAIL_LEN   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CH_W-1:0]  chan_i,
    input  logic             fast_clk_i,
    input  logic             rd_result_i,
    input  logic             cmp_i,
    output logic [CH_W-1:0]  mux_sel_o,
    output logic             sample_o,
    output logic [RES_W-1:0] dac_o,
    output logic             busy_o,
    output logic             done_o,
    output logic [RES_W-1:0] result_o
);
    localparam int BW = $clog2(RES_W);

    typedef struct packed {
        logic [CH_W-1:0] chan;
        logic            fast;
        logic            done;
    } top_state_t;

    top_state_t    st_d, st_q;
    logic          start_ok;
    logic          tick;
    logic          decide;
    logic [BW-1:0] bit_idx;
    logic          strobe;
    logic          finish;

    assign start_ok = start_i && !busy_o;

    adc_prescaler #(.DIV(DIV)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (busy_o),
        .restart_i (start_ok),
        .fast_i    (st_q.fast),
        .tick_o    (tick)
    );

    adc_phase_ctrl #(
        .RES_W      (RES_W),
        .SAMPLE_LEN (SAMPLE_LEN),
        .BIT_LEN    (BIT_LEN),
        .TAIL_LEN   (TAIL_LEN)
    ) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_ok_i (start_ok),
        .tick_i     (tick),
        .busy_o     (busy_o),
        .sample_o   (sample_o),
        .decide_o   (decide),
        .bit_idx_o  (bit_idx),
        .strobe_o   (strobe),
        .finish_o   (finish)
    );

    adc_sar_core #(.RES_W(RES_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_ok_i (start_ok),
        .decide_i   (decide),
        .bit_idx_i  (bit_idx),
        .strobe_i   (strobe),
        .finish_i   (finish),
        .cmp_i      (cmp_i),
        .dac_o      (dac_o),
        .result_o   (result_o)
    );

    always_comb begin
        st_d = st_q;
        if (start_ok) begin
            st_d.chan = chan_i;
            st_d.fast = fast_clk_i;
        end
        if (finish) begin
            st_d.done = 1'b1;
        end else if (start_ok || rd_result_i) begin
            st_d.done = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mux_sel_o = st_q.chan;
    assign done_o    = st_q.done;

    p_done_at_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    p_busy_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> $stable(mux_sel_o));

    p_start_clears_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (busy_o && !done_o));

endmodule

// File: tb/adc_sar_seq_tb.sv
module adc_sar_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 4;
    localparam int FRAME      = 26;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [2:0] chan_i = '0;
    logic       fast_clk_i = 1'b0;
    logic       rd_result_i = 1'b0;
    logic       cmp_i;
    logic [2:0] mux_sel_o;
    logic       sample_o;
    logic [7:0] dac_o;
    logic       busy_o;
    logic       done_o;
    logic [7:0] result_o;

    logic [7:0] vin_ch [8];
    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Behavioural comparator on the selected channel
    assign cmp_i = (vin_ch[mux_sel_o] >= dac_o);

    adc_sar_seq #(.DIV(DIV)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .chan_i      (chan_i),
        .fast_clk_i  (fast_clk_i),
        .rd_result_i (rd_result_i),
        .cmp_i       (cmp_i),
        .mux_sel_o   (mux_sel_o),
        .sample_o    (sample_o),
        .dac_o       (dac_o),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .result_o    (result_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] sar_ref(input logic [7:0] vin);
        logic [7:0] acc = '0;
        for (int b = 7; b >= 0; b--) begin
            logic [7:0] t;
            t = acc | (8'd1 << b);
            if (vin >= t) acc = t;
        end
        return acc;
    endfunction

    // One full conversion with per-cycle checks
    task automatic run_conv(input logic [2:0] ch, input bit fast, input bit inject,
                            input bit rd_at_end);
        int p;
        logic [7:0] exp_code;
        p = fast ? 1 : DIV;
        exp_code = sar_ref(vin_ch[ch]);
        @(negedge clk);
        start_i = 1'b1; chan_i = ch; fast_clk_i = fast;
        @(negedge clk);
        start_i = 1'b0; fast_clk_i = ~fast;  // R2: later changes ignored
        chan_i = ch ^ 3'd5;
        for (int j = 0; j <= FRAME * p; j++) begin
            int per;
            if (j > 0) @(negedge clk);
            per = j / p;
            if (j < FRAME * p) begin
                check(busy_o == 1'b1, "R1 busy during frame", busy_o, 1);
                check(sample_o == (per < 6), "R3 sample window", sample_o, int'(per < 6));
                check(mux_sel_o == ch, "R4 channel held", mux_sel_o, ch);
                check(done_o == 1'b0, "R8 done cleared by start", done_o, 0);
                if (per >= 6 && per < 22) begin
                    int b;
                    logic [7:0] lowm;
                    b = 7 - (per - 6) / 2;
                    lowm = (8'd1 << b) - 8'd1;
                    check(dac_o[b] == 1'b1, "R5 trial bit set", dac_o, b);
                    check((dac_o & lowm) == 8'd0, "R5 lower bits clear", dac_o, 0);
                    check((dac_o >> (b + 1)) == (exp_code >> (b + 1)),
                          "R6 kept decisions", dac_o, exp_code);
                end
            end else begin
                check(busy_o == 1'b0, "R1 busy ends after 26 periods", busy_o, 0);
                check(done_o == 1'b1, "R7 done at end", done_o, 1);
                check(result_o == exp_code, "R6 result code", result_o, exp_code);
                check(sample_o == 1'b0, "R3 sample idle", sample_o, 0);
            end
            // R9: start while busy, different channel
            if (inject && j == 10 * p) begin
                start_i = 1'b1; chan_i = ch ^ 3'd3;
            end else begin
                start_i = 1'b0;
            end
            // R8: read on the completion edge loses to completion
            rd_result_i = (rd_at_end && j == FRAME * p - 1);
        end
        rd_result_i = 1'b0;
    endtask

    task automatic read_result(input logic [7:0] exp_code);
        @(negedge clk);
        rd_result_i = 1'b1;
        @(negedge clk);
        rd_result_i = 1'b0;
        check(done_o == 1'b0, "R8 read clears done", done_o, 0);
        check(result_o == exp_code, "R6 result kept after read", result_o, exp_code);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        for (int c = 0; c < 8; c++) vin_ch[c] = 8'(c * 31 + 7);
        repeat (3) @(negedge clk);
        // R10 reset state
        check(busy_o == 0, "R10 busy reset", busy_o, 0);
        check(done_o == 0, "R10 done reset", done_o, 0);
        check(sample_o == 0, "R10 sample reset", sample_o, 0);
        check(result_o == 0, "R10 result reset", result_o, 0);
        check(dac_o == 0, "R10 dac reset", dac_o, 0);
        check(mux_sel_o == 0, "R10 mux reset", mux_sel_o, 0);
        rst_n = 1'b1;

        // Directed corners
        vin_ch[0] = 8'h00;
        run_conv(3'd0, 1'b1, 1'b0, 1'b0);
        read_result(8'h00);
        vin_ch[7] = 8'hFF;
        run_conv(3'd7, 1'b0, 1'b0, 1'b0);
        read_result(8'hFF);
        vin_ch[4] = 8'h80;
        run_conv(3'd4, 1'b0, 1'b1, 1'b1);
        vin_ch[2] = 8'h7F;
        run_conv(3'd2, 1'b1, 1'b1, 1'b0);   // new start clears previous done
        read_result(8'h7F);
        // R8 idle start request while idle after read, done stays clear until end
        vin_ch[5] = 8'h55;
        run_conv(3'd5, 1'b0, 1'b0, 1'b1);

        // Random mix
        for (int n = 0; n < 40; n++) begin
            logic [2:0] ch;
            bit fast, inj, rde;
            for (int c = 0; c < 8; c++) vin_ch[c] = 8'($urandom);
            ch   = 3'($urandom);
            fast = 1'($urandom);
            inj  = 1'($urandom);
            rde  = 1'($urandom);
            run_conv(ch, fast, inj, rde);
            if ($urandom % 2 == 0) read_result(sar_ref(vin_ch[ch]));
            repeat ($urandom % 4) @(negedge clk);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule